// File: doc/BRIEF.md
# Synthesizer Serial Register Loader

This block configures a fractional-N frequency synthesizer whose only control path is a write-only, three-wire serial link. The link has a data line, a serial clock and a latch strobe. The host fills a bank of six 32-bit configuration words through a parallel write port. It then issues a start request. The loader shifts every word out, beginning with word 5 and ending with word 0, and latches each word with a strobe pulse. At the end of the pass it raises a one-cycle completion pulse.

The host chooses the output power level and the RF output on/off setting on dedicated inputs. The loader merges these into word 4 as that word is loaded for shifting. The host can therefore change either setting and re-run a pass without touching the frequency words.

The serial clock is derived from the system clock. Its half period is set per pass by a divider input. The synthesizer's lock-detect line is synchronized and reported to the host as a lock flag. A sticky flag records any loss of lock that follows a lock.

Top module: `synth_cfg_loader`

## Requirements
- R1: A pass emits exactly six words in strictly descending index order: word 5 first, word 0 last. Each word ends with one rising edge of the latch strobe.
- R2: Each word is sent most-significant bit first as exactly 32 bits. The device samples on the rising edge of `ser_clk`. `ser_data` changes only while `ser_clk` falls, so it is steady while `ser_clk` is high.
- R3: The `ser_clk` half period is `div_half`+1 system cycles, with the value captured at start. Rising edges inside a word are therefore 2·(`div_half`+1) cycles apart. While no pass runs, `ser_clk`, `ser_le` and `ser_data` are all low.
- R4: `ser_le` stays low while bits shift. It rises together with the falling clock edge after bit 32 and stays high for 2·(`div_half`+1) cycles. `ser_clk` is low for the whole time `ser_le` is high.
- R5: Word 4 is sent with bits [4:3] replaced by `pwr_sel` and bit 5 replaced by `rf_on`. The `pwr_sel` codes are 0 = -4 dBm, 1 = -1 dBm, 2 = +2 dBm and 3 = +5 dBm. Every other bit of word 4, and every bit of the other words, is sent as written.
- R6: `busy` is high from the cycle after an accepted start until the cycle in which `done` pulses. `done` is high for exactly one cycle, and `busy` is already low in that cycle.
- R7: A start request while `busy` is high is ignored. No second pass and no extra words follow.
- R8: A bank write with `wr_en` high while idle stores `wr_data` at `wr_addr`, which takes values 0 to 5. A write while `busy` is high is ignored.
- R9: `locked` follows `lock_in` through two flip-flops. A change of `lock_in` appears on `locked` after the second rising clock edge.
- R10: `lock_lost` is set when `locked` falls and stays set until a start is accepted, which clears it. If a fall and an accepted start fall on the same edge, the set wins.
- R11: After reset, `busy`, `done`, `ser_data`, `ser_clk`, `ser_le`, `locked` and `lock_lost` are low, and all six bank words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bank write strobe |
| wr_addr | input | 3 | Bank word index 0..5 |
| wr_data | input | 32 | Bank write data |
| pwr_sel | input | 2 | Output power code merged into word 4 |
| rf_on | input | 1 | RF output enable merged into word 4 |
| div_half | input | 8 | Serial clock half period minus one, in system cycles |
| start | input | 1 | Start a programming pass |
| lock_in | input | 1 | Asynchronous lock-detect from synthesizer |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at end of pass |
| ser_data | output | 1 | Serial data to synthesizer |
| ser_clk | output | 1 | Serial clock to synthesizer |
| ser_le | output | 1 | Latch strobe to synthesizer |
| locked | output | 1 | Synchronized lock status |
| lock_lost | output | 1 | Sticky loss-of-lock flag |

## Verification
A loss of lock and the acceptance of a new start can reach the sticky lock-lost flag on the same clock edge: the loss sets the flag and the start clears it. The bench provokes this by dropping `lock_in` one cycle before it raises `start`. That timing makes the falling edge of the synchronized lock line land on the edge that accepts the start. The bench then expects `lock_lost` high and `busy` high together. This shows the set has priority and that the new pass was still accepted.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 6;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int OUT_WORD  = 4;   // word carrying output control fields
  localparam int PWR_LSB   = 3;   // two-bit power code position
  localparam int RFEN_BIT  = 5;   // RF output enable position

  typedef enum logic [1:0] {SH_IDLE, SH_BITS, SH_LATCH} sh_state_t;

  // Overlay power code and RF enable onto a raw output-control word.
  function automatic logic [WORD_W-1:0] merge_out_ctrl(
    input logic [WORD_W-1:0] raw,
    input logic [1:0]        pwr,
    input logic              en
  );
    logic [WORD_W-1:0] w;
    w = raw;
    w[PWR_LSB +: 2] = pwr;
    w[RFEN_BIT]     = en;
    return w;
  endfunction
endpackage

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfg_word_shifter.sv
module cfg_word_shifter
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              tick,
  input  logic [WORD_W-1:0] word_in,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              word_load,
  output logic              busy,
  output logic              done,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_le
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  sh_state_t         state;
  logic [WORD_W-1:0] shreg;
  logic [BIT_W-1:0]  bitcnt;
  logic              lhalf;
  logic              last_bit;
  logic              latch_end;
  logic              finish;

  assign busy      = (state != SH_IDLE);
  assign ser_data  = shreg[WORD_W-1];
  assign last_bit  = (bitcnt == BIT_W'(WORD_W - 1));
  assign latch_end = (state == SH_LATCH) && tick && lhalf;
  assign finish    = latch_end && (cur_idx == '0);
  assign word_load = start_acc || (latch_end && (cur_idx != '0));
  assign sel_idx   = start_acc ? LAST_IDX : IDX_W'(cur_idx - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SH_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      cur_idx <= '0;
      lhalf   <= 1'b0;
      ser_clk <= 1'b0;
      ser_le  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (word_load) begin
        shreg   <= word_in;
        cur_idx <= sel_idx;
        bitcnt  <= '0;
        lhalf   <= 1'b0;
        ser_clk <= 1'b0;
        ser_le  <= 1'b0;
        state   <= SH_BITS;
      end else begin
        case (state)
          SH_BITS: if (tick) begin
            if (!ser_clk) begin
              ser_clk <= 1'b1;
            end else begin
              ser_clk <= 1'b0;
              shreg   <= shreg << 1;
              if (last_bit) begin
                state  <= SH_LATCH;
                ser_le <= 1'b1;
                lhalf  <= 1'b0;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          SH_LATCH: if (tick) begin
            if (!lhalf) begin
              lhalf <= 1'b1;
            end else begin
              ser_le <= 1'b0;
              shreg  <= '0;
              state  <= SH_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lock_watch.sv
module lock_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_in,
  input  logic clr,
  output logic locked,
  output logic lost
);
  logic sync1;
  logic sync2;
  logic lock_fall;

  assign locked    = sync2;
  assign lock_fall = sync2 && !sync1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      lost  <= 1'b0;
    end else begin
      sync1 <= lock_in;
      sync2 <= sync1;
      if (lock_fall)  lost <= 1'b1;
      else if (clr)   lost <= 1'b0;
    end
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        pwr_sel,
  input  logic              rf_on,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              start,
  input  logic              lock_in,
  output logic              busy,
  output logic              done,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_le,
  output logic              locked,
  output logic              lock_lost
);
  logic [WORD_W-1:0] bank [NUM_WORDS];
  logic [DIV_W-1:0]  div_q;
  logic [IDX_W-1:0]  sel_idx;
  logic [IDX_W-1:0]  cur_idx;
  logic [WORD_W-1:0] raw_word;
  logic [WORD_W-1:0] word_in;
  logic              start_acc;
  logic              word_load;
  logic              tick;

  assign start_acc = start && !busy;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[g] <= '0;
      else if (wr_en && !busy && (wr_addr == IDX_W'(g)))
        bank[g] <= wr_data;
    end
  end

  assign raw_word = bank[sel_idx];
  assign word_in  = (sel_idx == IDX_W'(OUT_WORD)) ?
                    merge_out_ctrl(raw_word, pwr_sel, rf_on) : raw_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (start_acc) div_q <= div_half;
  end

  sclk_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div   (div_q),
    .tick  (tick)
  );

  cfg_word_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .tick      (tick),
    .word_in   (word_in),
    .sel_idx   (sel_idx),
    .cur_idx   (cur_idx),
    .word_load (word_load),
    .busy      (busy),
    .done      (done),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .ser_le    (ser_le)
  );

  lock_watch u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_in (lock_in),
    .clr     (start_acc),
    .locked  (locked),
    .lost    (lock_lost)
  );
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       ser_data,
  input logic       ser_clk,
  input logic       ser_le,
  input logic       lock_in,
  input logic       locked,
  input logic       lock_lost,
  input logic       word_load,
  input logic [2:0] word_idx
);
  // R1: a new pass begins with word 5
  a_r1_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (word_idx == 3'd5));
  // R1: a pass ends on word 0
  a_r1_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word_idx == 3'd0));
  // R1: mid-pass loads step down by one
  a_r1_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && busy) |=> (word_idx == $past(word_idx) - 3'd1));
  // R2: data steady while serial clock stays high
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  // R3: link quiet when idle
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_le && !ser_data));
  // R4: clock low while latch strobe high
  a_r4_le_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk);
  // R6: done is a single-cycle pulse closing a busy interval
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R9: lock status delayed by two flops
  a_r9_lock_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(lock_in, 2));
  // R10: loss of lock is flagged at once
  a_r10_lost_set: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> lock_lost);
endmodule

bind synth_cfg_loader synth_cfg_loader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .ser_data  (ser_data),
  .ser_clk   (ser_clk),
  .ser_le    (ser_le),
  .lock_in   (lock_in),
  .locked    (locked),
  .lock_lost (lock_lost),
  .word_load (word_load),
  .word_idx  (cur_idx)
);

// File: tb/synth_cfg_loader_tb_top.sv
module synth_cfg_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  pwr_sel = '0;
  logic        rf_on = 1'b0;
  logic [7:0]  div_half = 8'd1;
  logic        start = 1'b0;
  logic        lock_in = 1'b0;
  logic        busy, done, ser_data, ser_clk, ser_le, locked, lock_lost;

  int checks = 0;
  int errors = 0;

  logic [31:0] model [6];
  logic [31:0] cap [8];
  int          nbits [8];
  int          ncap = 0;
  logic [31:0] sh = '0;
  int          nb = 0;
  int          cyc = 0;
  int          last_rise = -1;
  int          le_start = 0;
  int          exp_per = 4;
  int          per_bad = 0;
  int          le_bad = 0;
  logic        prev_c = 1'b0;
  logic        prev_l = 1'b0;

  always #10 clk = ~clk;

  synth_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwr_sel(pwr_sel), .rf_on(rf_on),
    .div_half(div_half), .start(start), .lock_in(lock_in),
    .busy(busy), .done(done), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_le(ser_le), .locked(locked), .lock_lost(lock_lost)
  );

  // Link monitor: samples away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (ser_clk && !prev_c) begin
      sh = {sh[30:0], ser_data};
      nb++;
      if (nb > 1 && (cyc - last_rise) != exp_per) per_bad++;
      last_rise = cyc;
      if (ser_le) le_bad++;
    end
    if (ser_le && !prev_l) begin
      if (ser_clk) le_bad++;
      if (ncap < 8) begin
        cap[ncap]   = sh;
        nbits[ncap] = nb;
      end
      ncap++;
      nb = 0;
      le_start = cyc;
    end
    if (!ser_le && prev_l && (cyc - le_start) != exp_per) le_bad++;
    prev_c = ser_clk;
    prev_l = ser_le;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input int idx,
      input logic [1:0] p, input logic en);
    logic [31:0] w;
    w = model[idx];
    if (idx == 4) w = (w & ~32'h0000_0038) | ({31'd0, en} << 5) | ({30'd0, p} << 3);
    return w;
  endfunction

  task automatic bank_write(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic launch(input logic [7:0] dv, input logic [1:0] p, input logic en);
    @(negedge clk);
    div_half = dv; pwr_sel = p; rf_on = en;
    exp_per = 2 * (int'(dv) + 1);
    ncap = 0; nb = 0; per_bad = 0; le_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done === 1'b1, "R6", "done pulse seen", 32'(done), 32'd1);
    chk(busy === 1'b0, "R6", "busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk(done === 1'b0, "R6", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic check_pass(input logic [1:0] p, input logic en);
    chk(ncap == 6, "R1", "word count", 32'(ncap), 32'd6);
    for (int i = 0; i < 6; i++) begin
      chk(cap[i] === expect_word(5 - i, p, en), (5 - i == 4) ? "R5" : "R1",
          "word content/order", cap[i], expect_word(5 - i, p, en));
      chk(nbits[i] == 32, "R2", "bits per word", 32'(nbits[i]), 32'd32);
    end
    chk(per_bad == 0, "R3", "sclk period", 32'(per_bad), 32'd0);
    chk(le_bad == 0, "R4", "latch strobe shape", 32'(le_bad), 32'd0);
    chk(!ser_clk && !ser_le && !ser_data, "R3", "idle link low",
        {29'd0, ser_clk, ser_le, ser_data}, 32'd0);
  endtask

  task automatic t_reset;
    chk({busy, done, ser_data, ser_clk, ser_le, locked, lock_lost} === 7'd0,
        "R11", "reset outputs", {25'd0, busy, done, ser_data, ser_clk, ser_le, locked, lock_lost}, 32'd0);
    for (int i = 0; i < 6; i++) model[i] = '0;
    launch(8'd0, 2'd0, 1'b0);
    wait_done();
    check_pass(2'd0, 1'b0);   // R11: bank words all zero after reset
  endtask

  task automatic t_basic_pass;
    for (int i = 0; i < 6; i++) begin
      model[i] = 32'h1357_9BDF ^ (32'h0101_0101 * (i + 1)) ^ (32'h0000_0038 * i);
      bank_write(i, model[i]);   // R8: idle writes stored
    end
    model[4] = 32'hFFFF_FFC7;
    bank_write(4, model[4]);
    launch(8'd1, 2'd3, 1'b1);
    chk(busy === 1'b1, "R6", "busy after start", 32'(busy), 32'd1);
    wait_done();
    check_pass(2'd3, 1'b1);
  endtask

  task automatic t_power_clear;
    model[4] = 32'h0000_0038;
    bank_write(4, model[4]);
    launch(8'd3, 2'd0, 1'b0);
    wait_done();
    check_pass(2'd0, 1'b0);   // R5 fields forced to zero
    launch(8'd2, 2'd2, 1'b1);
    wait_done();
    check_pass(2'd2, 1'b1);   // R5 other code, R3 other divider
  endtask

  task automatic t_busy_ignores;
    logic [31:0] old0;
    old0 = model[0];
    launch(8'd1, 2'd1, 1'b0);
    repeat (40) @(negedge clk);
    start = 1'b1;                 // R7: start while busy
    @(negedge clk);
    start = 1'b0;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'hDEAD_BEEF;   // R8 busy write
    @(negedge clk);
    wr_en = 1'b0;
    wait_done();
    check_pass(2'd1, 1'b0);
    repeat (300) @(negedge clk);
    chk(ncap == 6 && !busy, "R7", "no second pass", 32'(ncap), 32'd6);
    launch(8'd0, 2'd1, 1'b0);
    wait_done();
    chk(cap[5] === old0, "R8", "busy write dropped", cap[5], old0);
  endtask

  task automatic t_lock;
    @(negedge clk);
    lock_in = 1'b1;
    @(negedge clk);
    chk(locked === 1'b0, "R9", "one edge not yet", 32'(locked), 32'd0);
    @(negedge clk);
    chk(locked === 1'b1, "R9", "locked after two", 32'(locked), 32'd1);
    lock_in = 1'b0;
    @(negedge clk);
    chk(lock_lost === 1'b0, "R10", "lost not yet", 32'(lock_lost), 32'd0);
    @(negedge clk);
    chk(lock_lost === 1'b1 && locked === 1'b0, "R10", "lost set",
        {30'd0, lock_lost, locked}, 32'd2);
    repeat (5) @(negedge clk);
    chk(lock_lost === 1'b1, "R10", "lost sticky", 32'(lock_lost), 32'd1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(lock_lost === 1'b0, "R10", "cleared by start", 32'(lock_lost), 32'd0);
    wait_done();
  endtask

  task automatic t_lost_meets_start;
    lock_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(locked === 1'b1 && lock_lost === 1'b0, "R10", "pre state",
        {30'd0, locked, lock_lost}, 32'd2);
    lock_in = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(lock_lost === 1'b1, "R10", "set wins over clear", 32'(lock_lost), 32'd1);
    chk(busy === 1'b1, "R10", "start still accepted", 32'(busy), 32'd1);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_pass();
    t_power_clear();
    t_busy_ignores();
    t_lock();
    t_lost_meets_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule